// File: doc/BRIEF.md
# Text-Cell Video Memory

This block stores the contents of an 80-column by 25-row text screen. Each cell has two bytes: a character code and a color attribute. A host reaches the storage through a synchronous SRAM-style port. The port has a 12-bit address, separate 8-bit write and read data buses, and an active-high write enable. The upper address bit picks the region: 0 selects characters and 1 selects attributes. The lower eleven bits give a linear cell index, counted row by row. Offsets from 2000 to 2047 in either region are holes with no storage behind them.

A second port is read-only and serves a raster renderer. It takes a cell column and row. One clock later it returns that cell's character and attribute together. Both ports work in every cycle and do not block each other. Reset clears the output registers but not the storage, so every cell has to be written before its contents mean anything.

Top module: `text_cell_mem`

## Requirements
- R1: A host write with address bit 11 = 0 and offset (bits 10:0) below 2000 stores the data as the character byte of cell `offset`; a later host read of that address returns it.
- R2: A host write with address bit 11 = 1 and offset below 2000 stores the data as the attribute byte of cell `offset`. The attribute of a cell is independent of its character.
- R3: `host_rdata_o` updates on every rising clock edge from the address sampled at that edge, whether or not a write happens. When a write and a read hit the same byte, the read returns the contents from before the write.
- R4: An offset of 2000 to 2047 in either region is unmapped. A write there changes no stored byte, and a read of it returns 0x00 one cycle later.
- R5: The display port computes the cell index as `row*80 + col`. The clock edge after the request, it returns that cell's character on `disp_char_o` and its attribute on `disp_attr_o`.
- R6: When the host writes the cell that the display port reads in the same cycle, the display port returns the cell's contents from before the write.
- R7: A display request with column of 80 or more, or row of 25 or more, returns 0x00 on both display outputs the next cycle.
- R8: While `rst_ni` is low, `host_rdata_o`, `disp_char_o` and `disp_attr_o` read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the output registers only |
| host_addr_i | input | 12 | Host address: bit 11 selects the region, bits 10:0 give the cell offset |
| host_wdata_i | input | 8 | Host write data |
| host_we_i | input | 1 | Host write enable, active high, sampled on the clock edge |
| host_rdata_o | output | 8 | Host read data for the address sampled at the last edge |
| disp_col_i | input | 7 | Display request column, 0 to 79 |
| disp_row_i | input | 5 | Display request row, 0 to 24 |
| disp_char_o | output | 8 | Character byte of the requested cell, one cycle after the request |
| disp_attr_o | output | 8 | Attribute byte of the requested cell, one cycle after the request |

## Verification
Each result is due after exactly one register stage. A host read or a display fetch presented before edge N appears on the outputs after edge N. The reference model therefore works out its expectation at edge N from the inputs and the stored contents at that moment. It applies that edge's write only after the expectation is fixed, and it compares against the outputs at the following falling edge. Bytes the bench has not yet written are marked unknown and skipped. Holes and out-of-range display requests are always checked against 0x00. Same-cycle collisions are checked against the value from before the write.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  typedef enum logic {
    REG_CHAR = 1'b0,
    REG_ATTR = 1'b1
  } region_e;

  localparam int unsigned NUM_REGIONS = 2;
endpackage

// File: rtl/tcm_addr_dec.sv
module tcm_addr_dec
  import tcm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CELLS  = 2000,
  parameter int unsigned IDX_W  = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned OFS_W = ADDR_W - 1;

  logic [OFS_W-1:0] ofs;

  assign ofs      = addr_i[OFS_W-1:0];
  assign region_o = region_e'(addr_i[ADDR_W-1]);
  assign hit_o    = (ofs < OFS_W'(CELLS));
  assign idx_o    = IDX_W'(ofs);
endmodule

// File: rtl/tcm_disp_index.sv
module tcm_disp_index #(
  parameter int unsigned COLS  = 80,
  parameter int unsigned ROWS  = 25,
  parameter int unsigned COL_W = 7,
  parameter int unsigned ROW_W = 5,
  parameter int unsigned IDX_W = 11
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             ok_o
);
  // wraps for out-of-range coordinates; ok_o masks those
  assign idx_o = IDX_W'(row_i) * IDX_W'(COLS) + IDX_W'(col_i);
  assign ok_o  = (32'(col_i) < COLS) && (32'(row_i) < ROWS);
endmodule

// File: rtl/tcm_cell_ram.sv
module tcm_cell_ram #(
  parameter int unsigned DEPTH  = 2000,
  parameter int unsigned IDX_W  = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_a_q, rd_b_q;

  // read-first on both read ports
  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_idx_i] <= wdata_i;
    rd_a_q <= mem[rd_a_idx_i];
    rd_b_q <= mem[rd_b_idx_i];
  end

  assign rd_a_o = rd_a_q;
  assign rd_b_o = rd_b_q;
endmodule

// File: rtl/text_cell_mem.sv
module text_cell_mem
  import tcm_pkg::*;
#(
  parameter  int unsigned COLS   = 80,
  parameter  int unsigned ROWS   = 25,
  parameter  int unsigned ADDR_W = 12,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned CELLS  = COLS * ROWS,
  localparam int unsigned IDX_W  = $clog2(CELLS),
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned ROW_W  = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_we_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic [COL_W-1:0]  disp_col_i,
  input  logic [ROW_W-1:0]  disp_row_i,
  output logic [DATA_W-1:0] disp_char_o,
  output logic [DATA_W-1:0] disp_attr_o
);
  region_e          host_region;
  logic             host_hit;
  logic [IDX_W-1:0] host_idx;
  logic [IDX_W-1:0] disp_idx;
  logic             disp_ok;

  logic [DATA_W-1:0] host_q [NUM_REGIONS];
  logic [DATA_W-1:0] disp_q [NUM_REGIONS];

  logic host_hit_q, host_attr_q, disp_ok_q;

  tcm_addr_dec #(
    .ADDR_W (ADDR_W),
    .CELLS  (CELLS),
    .IDX_W  (IDX_W)
  ) i_addr_dec (
    .addr_i   (host_addr_i),
    .region_o (host_region),
    .hit_o    (host_hit),
    .idx_o    (host_idx)
  );

  tcm_disp_index #(
    .COLS  (COLS),
    .ROWS  (ROWS),
    .COL_W (COL_W),
    .ROW_W (ROW_W),
    .IDX_W (IDX_W)
  ) i_disp_index (
    .col_i (disp_col_i),
    .row_i (disp_row_i),
    .idx_o (disp_idx),
    .ok_o  (disp_ok)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic region_we;
    assign region_we = host_we_i && host_hit && (host_region == region_e'(1'(g)));

    tcm_cell_ram #(
      .DEPTH  (CELLS),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W)
    ) i_cell_ram (
      .clk_i      (clk_i),
      .we_i       (region_we),
      .wr_idx_i   (host_idx),
      .wdata_i    (host_wdata_i),
      .rd_a_idx_i (host_idx),
      .rd_a_o     (host_q[g]),
      .rd_b_idx_i (disp_idx),
      .rd_b_o     (disp_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_hit_q  <= 1'b0;
      host_attr_q <= 1'b0;
      disp_ok_q   <= 1'b0;
    end else begin
      host_hit_q  <= host_hit;
      host_attr_q <= (host_region == REG_ATTR);
      disp_ok_q   <= disp_ok;
    end
  end

  // unmapped and out-of-range results forced to zero
  assign host_rdata_o = host_hit_q ? host_q[host_attr_q] : '0;
  assign disp_char_o  = disp_ok_q ? disp_q[REG_CHAR] : '0;
  assign disp_attr_o  = disp_ok_q ? disp_q[REG_ATTR] : '0;
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
  parameter  int unsigned COLS   = 80,
  parameter  int unsigned ROWS   = 25,
  parameter  int unsigned ADDR_W = 12,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned CELLS  = COLS * ROWS,
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned OFS_W  = ADDR_W - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              host_we_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic [COL_W-1:0]  disp_col_i,
  input logic [ROW_W-1:0]  disp_row_i,
  input logic [DATA_W-1:0] disp_char_o,
  input logic [DATA_W-1:0] disp_attr_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r4_hole_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i[OFS_W-1:0] >= OFS_W'(CELLS)) |=> (host_rdata_o == '0));

  a_r7_oob_disp_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((32'(disp_col_i) >= COLS) || (32'(disp_row_i) >= ROWS))
      |=> ((disp_char_o == '0) && (disp_attr_o == '0)));

  a_r3_host_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(host_we_i) && $stable(host_addr_i)) |=> $stable(host_rdata_o));

  a_r5_disp_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(host_we_i) && $stable(disp_col_i) && $stable(disp_row_i))
      |=> ($stable(disp_char_o) && $stable(disp_attr_o)));
endmodule

bind text_cell_mem tcm_checker #(
  .COLS   (COLS),
  .ROWS   (ROWS),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_tcm_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_addr_i  (host_addr_i),
  .host_we_i    (host_we_i),
  .host_rdata_o (host_rdata_o),
  .disp_col_i   (disp_col_i),
  .disp_row_i   (disp_row_i),
  .disp_char_o  (disp_char_o),
  .disp_attr_o  (disp_attr_o)
);

// File: tb/test_text_cell_mem.sv
module test_text_cell_mem;
  localparam int NCELL = 2000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [11:0] host_addr_i = '0;
  logic [7:0]  host_wdata_i = '0;
  logic        host_we_i = 1'b0;
  logic [7:0]  host_rdata_o;
  logic [6:0]  disp_col_i = '0;
  logic [4:0]  disp_row_i = '0;
  logic [7:0]  disp_char_o;
  logic [7:0]  disp_attr_o;

  always #5 clk_i = ~clk_i;

  text_cell_mem i_text_cell_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_we_i    (host_we_i),
    .host_rdata_o (host_rdata_o),
    .disp_col_i   (disp_col_i),
    .disp_row_i   (disp_row_i),
    .disp_char_o  (disp_char_o),
    .disp_attr_o  (disp_attr_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int char_m [NCELL];
  int attr_m [NCELL];
  bit char_k [NCELL];
  bit attr_k [NCELL];

  bit       exp_valid = 0;
  bit       host_known, disp_known;
  int       exp_host, exp_char, exp_attr;
  string    host_tag, disp_tag;

  // reference model: expectation fixed before this edge's write is applied
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      exp_valid = 0;
    end else begin
      int ofs, reg_sel, idx, col, row;
      ofs     = int'(host_addr_i[10:0]);
      reg_sel = int'(host_addr_i[11]);
      col     = int'(disp_col_i);
      row     = int'(disp_row_i);
      if (ofs >= NCELL) begin
        exp_host = 0; host_known = 1; host_tag = "R4";
      end else begin
        host_known = reg_sel ? attr_k[ofs] : char_k[ofs];
        exp_host   = reg_sel ? attr_m[ofs] : char_m[ofs];
        host_tag   = host_we_i ? "R3" : (reg_sel ? "R2" : "R1");
      end
      if (col >= 80 || row >= 25) begin
        exp_char = 0; exp_attr = 0; disp_known = 1; disp_tag = "R7";
      end else begin
        idx        = row * 80 + col;
        disp_known = char_k[idx] && attr_k[idx];
        exp_char   = char_m[idx];
        exp_attr   = attr_m[idx];
        disp_tag   = (host_we_i && ofs == idx) ? "R6" : "R5";
      end
      if (host_we_i && ofs < NCELL) begin
        if (reg_sel == 1) begin attr_m[ofs] = int'(host_wdata_i); attr_k[ofs] = 1; end
        else              begin char_m[ofs] = int'(host_wdata_i); char_k[ofs] = 1; end
      end
      exp_valid = 1;
    end
  end

  task automatic chk(input string tag, input string name, input logic [7:0] act, input int exp);
    checks++;
    if (act !== 8'(exp)) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, name, act, 8'(exp));
    end
  endtask

  task automatic cyc(input int addr, input int wd, input bit we, input int col, input int row);
    @(negedge clk_i);
    if (exp_valid) begin
      if (host_known) chk(host_tag, "host_rdata_o", host_rdata_o, exp_host);
      if (disp_known) begin
        chk(disp_tag, "disp_char_o", disp_char_o, exp_char);
        chk(disp_tag, "disp_attr_o", disp_attr_o, exp_attr);
      end
    end
    host_addr_i  = 12'(addr);
    host_wdata_i = 8'(wd);
    host_we_i    = we;
    disp_col_i   = 7'(col);
    disp_row_i   = 5'(row);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    #2 rst_ni = 1'b0;
    host_addr_i = 12'h123;
    disp_col_i  = 7'd5;
    // R8: outputs quiet while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R8", "host_rdata_o", host_rdata_o, 0);
      chk("R8", "disp_char_o", disp_char_o, 0);
      chk("R8", "disp_attr_o", disp_attr_o, 0);
    end
    rst_ni = 1'b1;

    // R1/R2: fill both regions while the display port scans
    for (int i = 0; i < NCELL; i++)
      cyc(i, (i * 7 + 3) & 8'hFF, 1, i % 80, (i / 80) % 25);
    for (int i = 0; i < NCELL; i++)
      cyc(12'h800 + i, (i ^ 8'h5A) & 8'hFF, 1, (i * 3) % 80, i % 25);

    // R4: writes into both holes
    for (int i = NCELL; i < 2048; i++) begin
      cyc(i, 8'hFF, 1, 0, 0);
      cyc(12'h800 + i, 8'hEE, 1, 79, 24);
    end

    // R1/R2/R4: read the whole address space back
    for (int a = 0; a < 4096; a++)
      cyc(a, 0, 0, 0, 0);

    // R5/R7: every column and row code, in and out of range
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < 128; c++)
        cyc((r * 128 + c) % 4096, 0, 0, c, r);

    // R6/R3: host writes the very cell being displayed
    for (int i = 0; i < 600; i++) begin
      int c, r, sel;
      c   = int'($urandom % 80);
      r   = int'($urandom % 25);
      sel = int'($urandom % 2);
      cyc(sel * 2048 + r * 80 + c, int'($urandom % 256), 1, c, r);
    end

    // mixed traffic
    for (int i = 0; i < 3000; i++)
      cyc(int'($urandom % 4096), int'($urandom % 256), bit'($urandom % 2),
          int'($urandom % 128), int'($urandom % 32));

    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    report();
  end
endmodule